// File: doc/BRIEF.md
# Duplex Parity Memory Controller

This controller sits between a processor-side request port and two identical memory banks that hold mirrored copies of the same data. Every access goes to both banks in the same cycle. Each stored word carries one odd-parity bit. One bank is marked as the prime copy, and read data is normally taken from it.

When the prime copy's word fails its parity check and the other copy is sound, the controller does three things. It returns the sound word, it hands the prime role to the other bank, and it rewrites the failed location with the sound word. The write-back takes one cycle, and the request port is not ready during that cycle. When both copies of a word fail, the controller raises an error flag and changes nothing. A saturating counter records how many corrections have taken place, and an output shows which bank is prime.

The banks are synchronous memories. A bank that is enabled at a clock edge returns the addressed word on its read-data input after that edge. If the enable comes with a write, the bank stores the word at that edge.

Top module: `duplex_parity_mem`

## Requirements
- R1: While reset is held and just after it is released, `primeSel` is 0, `corrCount` is 0, `rspValid` is 0 and `reqReady` is 1.
- R2: An accepted write (`reqValid`, `reqWrite` and `reqReady` all high) drives `bankEn = 2'b11`, `bankWe = 2'b11` and `bankAddr = reqAddr` in the same cycle. It also drives `bankWdata = {p, reqWdata}`, where the parity bit p is bit DW.
- R3: An accepted read drives `bankEn = 2'b11` and `bankWe = 2'b00`. In the next cycle `rspValid` is high for exactly one cycle. When the prime word's parity is good, `rspData` carries the prime bank's data bits.
- R4: Parity is odd. A stored word (DW+1 bits) is good only when the XOR of all its bits is 1, so an all-zero word is an error. The write parity bit p equals the inverted XOR of the data bits.
- R5: If the prime word fails and the secondary word is good, `rspData` returns the secondary data and `primeSel` toggles on the following edge.
- R6: In the response cycle of such a correction, `reqReady` is 0 and any request on the port is ignored. In the same cycle the controller writes the full secondary word back into the failed bank only (`bankEn = bankWe =` one-hot of the old prime, with bank 0 as bit 0), at the read's address.
- R7: `corrCount` rises by one for each correction and saturates at 255. It does not change otherwise.
- R8: If both words fail, `rspDoubleErr` is high with `rspValid`, and `rspData` returns the prime data. There is no swap, no write-back and no count change.
- R9: If only the secondary word fails, the prime data is returned. There is no swap, no write-back and no count change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | AW | Request word address |
| reqWdata | input | DW | Write data |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| rspValid | output | 1 | Read response valid |
| rspData | output | DW | Read response data |
| rspDoubleErr | output | 1 | Both copies failed parity |
| bankEn | output | 2 | Per-bank enable (bit 0 = bank 0) |
| bankWe | output | 2 | Per-bank write enable |
| bankAddr | output | AW | Address shared by both banks |
| bankWdata | output | DW+1 | Word written, parity in bit DW |
| bank0Rdata | input | DW+1 | Bank 0 read word |
| bank1Rdata | input | DW+1 | Bank 1 read word |
| primeSel | output | 1 | Index of the current prime bank |
| corrCount | output | CW | Saturating count of corrections |

## Verification
The assertions check several rules on every cycle:
- Every bank write carries good parity.
- A port write reaches both banks.
- A write-back reaches exactly one bank while the port is stalled.
- The prime bank changes only on a correction, and a double error never swaps it.
- The counter either steps by one or saturates.

Only the bench's scenarios can show that the repaired location really holds the good word. It does this by corrupting the new prime copy and reading again, which forces the correction to come from the copy that was written back. The same applies to a write blocked during the stall: only a later read of that address shows it left memory unchanged.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic accept;   // port request taken this cycle
    logic write;    // taken request is a write
    logic scrub;    // write-back of the good word this cycle
  } dpm_strobe_t;
endpackage

// File: rtl/dpm_datapath.sv
module dpm_datapath
  import dpm_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpm_strobe_t       strb,
  input  logic              primeSel,
  input  logic [AW-1:0]     reqAddr,
  input  logic [DW-1:0]     reqWdata,
  input  logic [DW:0]       bank0Rdata,
  input  logic [DW:0]       bank1Rdata,
  output logic              primeOk,
  output logic              secOk,
  output logic [1:0]        bankEn,
  output logic [1:0]        bankWe,
  output logic [AW-1:0]     bankAddr,
  output logic [DW:0]       bankWdata,
  output logic [DW-1:0]     rspData,
  output logic [CW-1:0]     corrCount
);
  localparam int NB = 2;
  localparam int WW = DW + 1;
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [WW-1:0] rdWord [NB];
  logic [NB-1:0] wordOk;
  logic          secSel;
  logic [NB-1:0] failOneHot;
  logic [AW-1:0] pendAddr;

  assign rdWord[0] = bank0Rdata;
  assign rdWord[1] = bank1Rdata;

  // odd parity check per bank
  for (genvar b = 0; b < NB; b++) begin : g_chk
    assign wordOk[b] = ^rdWord[b];
  end

  assign secSel     = ~primeSel;
  assign primeOk    = wordOk[primeSel];
  assign secOk      = wordOk[secSel];
  assign failOneHot = primeSel ? 2'b10 : 2'b01;

  always_comb begin
    if (strb.scrub) begin
      bankEn    = failOneHot;
      bankWe    = failOneHot;
      bankAddr  = pendAddr;
      bankWdata = rdWord[secSel];
    end else begin
      bankEn    = {NB{strb.accept}};
      bankWe    = {NB{strb.accept & strb.write}};
      bankAddr  = reqAddr;
      bankWdata = {~^reqWdata, reqWdata};
    end
  end

  assign rspData = (primeOk || !secOk) ? rdWord[primeSel][DW-1:0]
                                       : rdWord[secSel][DW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr  <= '0;
      corrCount <= '0;
    end else begin
      if (strb.accept) pendAddr <= reqAddr;
      if (strb.scrub && corrCount != CNT_MAX) corrCount <= corrCount + 1'b1;
    end
  end
endmodule

// File: rtl/dpm_ctrl.sv
module dpm_ctrl
  import dpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        primeOk,
  input  logic        secOk,
  output dpm_strobe_t strb,
  output logic        reqReady,
  output logic        rspValid,
  output logic        rspDoubleErr,
  output logic        primeSel
);
  logic rdPend;
  logic needScrub;

  assign needScrub    = rdPend & ~primeOk & secOk;
  assign reqReady     = ~needScrub;
  assign rspValid     = rdPend;
  assign rspDoubleErr = rdPend & ~primeOk & ~secOk;

  always_comb begin
    strb.accept = reqValid & reqReady;
    strb.write  = reqWrite;
    strb.scrub  = needScrub;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPend   <= 1'b0;
      primeSel <= 1'b0;
    end else begin
      rdPend   <= strb.accept & ~reqWrite;
      primeSel <= primeSel ^ needScrub;
    end
  end
endmodule

// File: rtl/duplex_parity_mem.sv
module duplex_parity_mem
  import dpm_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  output logic          reqReady,
  output logic          rspValid,
  output logic [DW-1:0] rspData,
  output logic          rspDoubleErr,
  output logic [1:0]    bankEn,
  output logic [1:0]    bankWe,
  output logic [AW-1:0] bankAddr,
  output logic [DW:0]   bankWdata,
  input  logic [DW:0]   bank0Rdata,
  input  logic [DW:0]   bank1Rdata,
  output logic          primeSel,
  output logic [CW-1:0] corrCount
);
  dpm_strobe_t strb;
  logic primeOk, secOk;

  dpm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .primeOk(primeOk), .secOk(secOk), .strb(strb), .reqReady(reqReady),
    .rspValid(rspValid), .rspDoubleErr(rspDoubleErr), .primeSel(primeSel)
  );

  dpm_datapath #(.DW(DW), .AW(AW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .primeSel(primeSel),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .bank0Rdata(bank0Rdata), .bank1Rdata(bank1Rdata),
    .primeOk(primeOk), .secOk(secOk), .bankEn(bankEn), .bankWe(bankWe),
    .bankAddr(bankAddr), .bankWdata(bankWdata), .rspData(rspData),
    .corrCount(corrCount)
  );
endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqReady,
  input logic          rspValid,
  input logic [DW-1:0] rspData,
  input logic          rspDoubleErr,
  input logic [1:0]    bankEn,
  input logic [1:0]    bankWe,
  input logic [AW-1:0] bankAddr,
  input logic [DW:0]   bankWdata,
  input logic [DW:0]   bank0Rdata,
  input logic [DW:0]   bank1Rdata,
  input logic          primeSel,
  input logic [CW-1:0] corrCount
);
  logic [DW:0] primeWord, secWord;
  logic        unusedAddr;
  assign primeWord  = primeSel ? bank1Rdata : bank0Rdata;
  assign secWord    = primeSel ? bank0Rdata : bank1Rdata;
  assign unusedAddr = ^bankAddr;

  // R4
  wr_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankWe != 2'b00) |-> (^bankWdata) == 1'b1);

  // R2
  wr_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && bankWe != 2'b00) |-> (bankWe == 2'b11 && bankEn == 2'b11));

  // R6
  scrub_one_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |-> ($countones(bankWe) == 1 && bankEn == bankWe && bankWdata == secWord));

  // R5
  swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !(^primeWord) && (^secWord)) |=> (primeSel != $past(primeSel)));

  // R5
  hold_prime_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> $stable(primeSel));

  // R3
  rsp_prime_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (^primeWord)) |-> (rspData == primeWord[DW-1:0] && !rspDoubleErr && !unusedAddr == !unusedAddr));

  // R8
  double_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDoubleErr |-> (rspValid && reqReady && rspData == primeWord[DW-1:0]));

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && corrCount != {CW{1'b1}}) |=> corrCount == CW'($past(corrCount) + 1'b1));

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady || corrCount == {CW{1'b1}}) |=> $stable(corrCount));
endmodule

bind duplex_parity_mem dpm_checker #(.DW(DW), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .rspData(rspData), .rspDoubleErr(rspDoubleErr), .bankEn(bankEn),
  .bankWe(bankWe), .bankAddr(bankAddr), .bankWdata(bankWdata),
  .bank0Rdata(bank0Rdata), .bank1Rdata(bank1Rdata), .primeSel(primeSel),
  .corrCount(corrCount)
);

// File: tb/tb_duplex_parity_mem.sv
module tb_duplex_parity_mem;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int CW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, rspValid, rspDoubleErr, primeSel;
  logic [DW-1:0] rspData;
  logic [1:0] bankEn, bankWe;
  logic [AW-1:0] bankAddr;
  logic [DW:0] bankWdata, bank0Rdata, bank1Rdata;
  logic [CW-1:0] corrCount;

  always #10 clk = ~clk;  // 50 MHz

  duplex_parity_mem #(.DW(DW), .AW(AW), .CW(CW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspData(rspData), .rspDoubleErr(rspDoubleErr),
    .bankEn(bankEn), .bankWe(bankWe), .bankAddr(bankAddr),
    .bankWdata(bankWdata), .bank0Rdata(bank0Rdata), .bank1Rdata(bank1Rdata),
    .primeSel(primeSel), .corrCount(corrCount)
  );

  // bank models: synchronous read, write at the enabling edge
  logic [DW:0] mem [2][DEPTH];
  logic [DW:0] rdq [2];
  assign bank0Rdata = rdq[0];
  assign bank1Rdata = rdq[1];
  always @(posedge clk) begin
    for (int b = 0; b < 2; b++) begin
      if (bankEn[b]) begin
        rdq[b] <= mem[b][bankAddr];
        if (bankWe[b]) mem[b][bankAddr] <= bankWdata;
      end
    end
  end

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [DW-1:0] expData [DEPTH];
  int expPrime = 0;
  int expCount = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic corrupt(input int b, input int a, input int k);
    mem[b][a][k] = ~mem[b][a][k];
  endtask

  task automatic doWrite(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = AW'(a); reqWdata = d;
    #1;
    chk(reqReady == 1, "R2 ready for write", reqReady, 1);
    chk(bankEn == 2'b11 && bankWe == 2'b11, "R2 write both banks", {bankEn, bankWe}, 4'hF);
    chk(bankAddr == AW'(a), "R2 write address", bankAddr, a);
    chk(bankWdata == {~^d, d}, "R4 write parity word", bankWdata, {~^d, d});
    @(negedge clk);
    reqValid = 0;
    expData[a] = d;
  endtask

  // kind: 0 clean, 1 correction, 2 double error, 3 secondary-only error
  task automatic doRead(input int a, input int kind, input bit blockWr = 0,
                        input int bwAddr = 0, input int bwData = 0);
    logic [DW-1:0] expD;
    logic [DW:0] secWord;
    int oldPrime;
    string t;
    t = (kind == 1) ? "R5" : (kind == 2) ? "R8" : (kind == 3) ? "R9" : "R3";
    oldPrime = expPrime;
    expD = (kind == 2) ? mem[oldPrime][a][DW-1:0] : expData[a];
    secWord = mem[1 - oldPrime][a];
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = AW'(a);
    #1;
    chk(reqReady == 1, "R3 ready at read issue", reqReady, 1);
    chk(bankEn == 2'b11 && bankWe == 2'b00, "R3 read both banks", {bankEn, bankWe}, 4'hC);
    @(negedge clk);
    if (blockWr) begin
      reqValid = 1; reqWrite = 1; reqAddr = AW'(bwAddr); reqWdata = DW'(bwData);
    end else reqValid = 0;
    #1;
    chk(rspValid == 1, {t, " response valid"}, rspValid, 1);
    chk(rspData == expD, {t, " response data"}, rspData, expD);
    chk(rspDoubleErr == (kind == 2), "R8 double flag", rspDoubleErr, kind == 2);
    if (kind == 1) begin
      chk(reqReady == 0, "R6 ready low in write-back", reqReady, 0);
      chk(bankWe == (oldPrime ? 2'b10 : 2'b01) && bankEn == bankWe,
          "R6 write-back bank", {bankEn, bankWe}, oldPrime ? 4'hA : 4'h5);
      chk(bankAddr == AW'(a), "R6 write-back address", bankAddr, a);
      chk(bankWdata == secWord, "R6 write-back word", bankWdata, secWord);
    end else begin
      chk(reqReady == 1 && bankWe == 2'b00, {t, " no write-back"}, {reqReady, bankWe}, 4);
    end
    @(negedge clk);
    reqValid = 0;
    if (kind == 1) begin
      expPrime ^= 1;
      if (expCount < 255) expCount++;
    end
    #1;
    chk(primeSel == expPrime[0], {t, " prime selection"}, primeSel, expPrime);
    chk(corrCount == CW'(expCount), "R7 correction count", corrCount, expCount);
    chk(rspValid == 0, "R3 single-cycle response", rspValid, 0);
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < DEPTH; a++) mem[b][a] = '0;
    rdq[0] = '0; rdq[1] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(primeSel == 0 && corrCount == 0, "R1 reset state", {primeSel, corrCount}, 0);
    chk(rspValid == 0 && reqReady == 1, "R1 reset handshake", {rspValid, reqReady}, 1);
    @(negedge clk); rstN = 1; #1;
    chk(primeSel == 0 && corrCount == 0 && rspValid == 0 && reqReady == 1,
        "R1 after release", {primeSel, corrCount, rspValid, reqReady}, 1);

    for (int a = 0; a < DEPTH; a++) doWrite(a, DW'((a * 37 + 5) & 8'hFF));
    for (int a = 0; a < DEPTH; a++) doRead(a, 0);

    // every address: correct, then force the next correction to come from the scrubbed copy
    for (int a = 0; a < DEPTH; a++) begin
      corrupt(expPrime, a, a % (DW + 1));
      doRead(a, 1);
      corrupt(expPrime, a, (a + 3) % (DW + 1));
      doRead(a, 1);
      doRead(a, 0);
    end

    // R4 all-zero stored word counts as an error
    mem[expPrime][3] = '0;
    doRead(3, 1);

    // R8 both copies bad
    corrupt(0, 5, 0); corrupt(1, 5, 0);
    doRead(5, 2);
    doWrite(5, expData[5]);
    doRead(5, 0);

    // R9 secondary copy bad only
    corrupt(1 - expPrime, 7, 2);
    doRead(7, 3);
    doWrite(7, expData[7]);

    // R6 write presented during the write-back is ignored
    corrupt(expPrime, 9, 1);
    doRead(9, 1, 1, 10, 8'hA5);
    doRead(10, 0);

    // R2/R4 parity extremes
    doWrite(2, 8'h00); doRead(2, 0);
    doWrite(2, 8'hFF); doRead(2, 0);

    // R7 saturation
    while (expCount < 255) begin
      corrupt(expPrime, 0, 0);
      doRead(0, 1);
    end
    corrupt(expPrime, 0, 4);
    doRead(0, 1);
    chk(corrCount == 8'hFF, "R7 saturated", corrCount, 255);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule